// File: doc/BRIEF.md
# Linked-List Descriptor DMA Engine

This block moves a programmed number of bytes between system memory and the data port of a card controller without processor help. Software places a chain of descriptors in memory, points the engine at the first one, and pulses a start request. Each descriptor is four 32-bit words at consecutive addresses: word 0 is status, word 1 is buffer size, word 2 is buffer address and word 3 is the address of the next descriptor. The engine reads a descriptor and moves that descriptor's share of the data. It then hands the descriptor back to software by clearing its ownership flag in memory. It then either follows the next-address word or stops.

Data passes through a small staging buffer. For a transmit (memory to card), up to `BURST_WORDS` words are read from memory into the buffer and then presented to the card as a word stream. For a receive (card to memory), up to `BURST_WORDS` words are collected from the card and then written to memory. Memory accesses use a single-word request/acknowledge master. When a transfer completes, the engine raises completion flags in a raw interrupt status vector and in a DMA status vector. Both vectors are cleared when the next transfer is accepted.

The sequencer has these states: IDLE, FETCH, PLAN, CHUNK, MEM_RD, CARD_OUT, CARD_IN, MEM_WR, WBACK, NEXT and DONE. The transitions are as follows:
- IDLE goes to FETCH on an accepted start.
- FETCH goes to PLAN after the fourth descriptor word is acknowledged.
- PLAN goes to CHUNK.
- CHUNK goes to MEM_RD for a transmit and to CARD_IN for a receive.
- MEM_RD goes to CARD_OUT, and CARD_IN goes to MEM_WR, once the chunk's last word is handled.
- CARD_OUT and MEM_WR go to CHUNK while words remain in the descriptor, and to WBACK otherwise.
- WBACK goes to NEXT when the write-back is acknowledged.
- NEXT goes to DONE on a last flag or when no bytes remain, and to FETCH otherwise.
- DONE goes to IDLE.

Top module: `sdd_dma_engine`

## Requirements
- R1: A start pulse is accepted only if `dma_en` is 1, `byte_count` is non-zero, `block_size` is non-zero, and either `dir_write` is 1 or `card_ready` is 1. A refused start causes no memory or card activity and leaves `bytes_left`, `irq_raw` and `dma_stat` unchanged.
- R2: A descriptor is read as four words at its base address plus 0, 4, 8 and 12, in that order: status, size, buffer address, next address. The first descriptor's base is `desc_base`.
- R3: A size word of zero, or one above `MAX_DESC_BYTES`, is treated as `MAX_DESC_BYTES` (default 8192).
- R4: Bits 1:0 of the buffer address word are ignored, and every memory access is word aligned.
- R5: Each descriptor moves n = min(effective size, bytes remaining) bytes as ceil(n/4) whole words, in address order, to consecutive buffer addresses. `bytes_left` then drops by n and saturates at zero.
- R6: After a descriptor's data has moved, its status word is written back to the descriptor base with bit 31 (ownership) cleared and all other bits kept. This write is the last memory write for that descriptor.
- R7: The walk ends after a descriptor whose status bit 2 (last) is set, or once `bytes_left` reaches zero. Otherwise the engine fetches the descriptor at that descriptor's next-address word.
- R8: On completion `irq_raw` bits 3 (data done) and 16 (card interrupt) are set. `dma_stat` bit 8 (summary) is set, together with bit 0 for a transmit or bit 1 for a receive. Both vectors read zero from the cycle after an accepted start, and `busy` is low in the cycle the flags appear.
- R9: A memory request keeps its address, write enable and write data until acknowledged. An offered card word keeps its value until `card_wready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start request pulse |
| dir_write | input | 1 | 1 = memory to card, 0 = card to memory |
| dma_en | input | 1 | DMA enable |
| card_ready | input | 1 | Card has read data available |
| byte_count | input | 32 | Total bytes to move |
| block_size | input | 32 | Card block size, must be non-zero |
| desc_base | input | 32 | Address of first descriptor |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Memory byte address, word aligned |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory access accepted this cycle |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |
| card_wvalid | output | 1 | Word offered to the card |
| card_wdata | output | 32 | Word to the card |
| card_wready | input | 1 | Card accepts the offered word |
| card_rvalid | input | 1 | Card offers a word |
| card_rdata | input | 32 | Word from the card |
| card_rready | output | 1 | Engine accepts a card word |
| busy | output | 1 | Transfer in progress |
| bytes_left | output | 32 | Bytes still to move |
| irq_raw | output | 32 | Raw completion flags |
| dma_stat | output | 10 | DMA status flags |

## Verification
The hardest situation to reach from the ports is a chain in which the last flag and the byte count disagree. In one case a descriptor is cut short by the remaining count and the walk ends without any last flag. In the other case the last flag ends the walk while bytes still remain. The stimulus builds both cases in the bench memory, and a trap descriptor is placed after the stopping point, so any extra fetch or write-back shows up as an unexpected memory write. Oversized and zero size words are combined with a byte count just past the maximum, so that the clamp decides how the bytes split across two descriptors. Random stalls on memory acknowledge and on both card handshakes drive every hold path.

// File: rtl/sdd_pkg.sv
package sdd_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_FETCH,
        S_PLAN,
        S_CHUNK,
        S_MEM_RD,
        S_CARD_OUT,
        S_CARD_IN,
        S_MEM_WR,
        S_WBACK,
        S_NEXT,
        S_DONE
    } sdd_state_e;

    // descriptor status word bits
    localparam int OWN_BIT  = 31;
    localparam int LAST_BIT = 2;

    // completion flag positions
    localparam int RAW_DATA_DONE = 3;
    localparam int RAW_CARD_IRQ  = 16;
    localparam int STAT_TX       = 0;
    localparam int STAT_RX       = 1;
    localparam int STAT_SUM      = 8;

endpackage

// File: rtl/sdd_len_calc.sv
module sdd_len_calc #(
    parameter int MAX_DESC_BYTES = 8192,
    localparam int WCNT_W = $clog2(MAX_DESC_BYTES / 4 + 1) + 1
) (
    input  logic [31:0]       size_field,
    input  logic [31:0]       remaining,
    output logic [31:0]       xfer_bytes,
    output logic [WCNT_W-1:0] xfer_words
);

    localparam logic [31:0] MAXB = 32'(MAX_DESC_BYTES);

    logic [31:0] eff_size;
    logic [31:0] rounded;

    always_comb begin
        // zero or oversized size fields collapse onto the ceiling
        if (size_field == 32'd0 || size_field > MAXB) begin
            eff_size = MAXB;
        end else begin
            eff_size = size_field;
        end
        xfer_bytes = (eff_size < remaining) ? eff_size : remaining;
        rounded    = (xfer_bytes + 32'd3) >> 2;
        xfer_words = WCNT_W'(rounded);
    end

endmodule

// File: rtl/sdd_stage_buf.sv
module sdd_stage_buf #(
    parameter int DEPTH = 4,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [31:0]   wdata,
    input  logic [AW-1:0] raddr,
    output logic [31:0]   rdata
);

    logic [31:0] slot [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (we && waddr == AW'(g)) begin
                slot[g] <= wdata;
            end
        end
    end

    assign rdata = slot[raddr];

endmodule

// File: rtl/sdd_dma_engine.sv
module sdd_dma_engine
    import sdd_pkg::*;
#(
    parameter int MAX_DESC_BYTES = 8192,
    parameter int BURST_WORDS    = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        dir_write,
    input  logic        dma_en,
    input  logic        card_ready,
    input  logic [31:0] byte_count,
    input  logic [31:0] block_size,
    input  logic [31:0] desc_base,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic        mem_ack,
    input  logic [31:0] mem_rdata,
    output logic        card_wvalid,
    output logic [31:0] card_wdata,
    input  logic        card_wready,
    input  logic        card_rvalid,
    input  logic [31:0] card_rdata,
    output logic        card_rready,
    output logic        busy,
    output logic [31:0] bytes_left,
    output logic [31:0] irq_raw,
    output logic [9:0]  dma_stat
);

    localparam int WCNT_W = $clog2(MAX_DESC_BYTES / 4 + 1) + 1;
    localparam int IW     = $clog2(BURST_WORDS + 1);
    localparam int BAW    = (BURST_WORDS > 1) ? $clog2(BURST_WORDS) : 1;

    sdd_state_e state_q, state_d;

    logic [31:0]       desc_addr;
    logic [31:0]       d_status;
    logic [31:0]       d_size;
    logic [31:2]       d_buf;
    logic [31:0]       d_next;
    logic [1:0]        fetch_i;
    logic [31:0]       remaining;
    logic [31:0]       xfer_q;
    logic [WCNT_W-1:0] words_left;
    logic [IW-1:0]     chunk;
    logic [IW-1:0]     idx;
    logic [31:0]       cur_addr;
    logic              is_wr;

    logic [31:0]       calc_bytes;
    logic [WCNT_W-1:0] calc_words;
    logic              buf_we;
    logic [31:0]       buf_wdata;
    logic [31:0]       buf_rdata;

    logic accept;
    logic last_beat;
    logic chunk_final;
    logic [IW-1:0] chunk_pick;

    assign accept = start && dma_en && (byte_count != 32'd0) &&
                    (block_size != 32'd0) && (dir_write || card_ready);
    assign last_beat   = (idx == chunk - IW'(1));
    assign chunk_final = (words_left == WCNT_W'(chunk));
    assign chunk_pick  = (words_left < WCNT_W'(BURST_WORDS)) ?
                         IW'(words_left) : IW'(BURST_WORDS);

    sdd_len_calc #(.MAX_DESC_BYTES(MAX_DESC_BYTES)) u_len (
        .size_field (d_size),
        .remaining  (remaining),
        .xfer_bytes (calc_bytes),
        .xfer_words (calc_words)
    );

    sdd_stage_buf #(.DEPTH(BURST_WORDS)) u_buf (
        .clk   (clk),
        .we    (buf_we),
        .waddr (BAW'(idx)),
        .wdata (buf_wdata),
        .raddr (BAW'(idx)),
        .rdata (buf_rdata)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:     if (accept) state_d = S_FETCH;
            S_FETCH:    if (mem_ack && fetch_i == 2'd3) state_d = S_PLAN;
            S_PLAN:     state_d = S_CHUNK;
            S_CHUNK:    state_d = is_wr ? S_MEM_RD : S_CARD_IN;
            S_MEM_RD:   if (mem_ack && last_beat) state_d = S_CARD_OUT;
            S_CARD_OUT: if (card_wready && last_beat)
                            state_d = chunk_final ? S_WBACK : S_CHUNK;
            S_CARD_IN:  if (card_rvalid && last_beat) state_d = S_MEM_WR;
            S_MEM_WR:   if (mem_ack && last_beat)
                            state_d = chunk_final ? S_WBACK : S_CHUNK;
            S_WBACK:    if (mem_ack) state_d = S_NEXT;
            S_NEXT:     state_d = (d_status[LAST_BIT] || remaining == 32'd0) ?
                                  S_DONE : S_FETCH;
            S_DONE:     state_d = S_IDLE;
            default:    state_d = S_IDLE;
        endcase
    end

    // outputs decoded from state
    always_comb begin
        mem_req     = 1'b0;
        mem_we      = 1'b0;
        mem_addr    = 32'd0;
        mem_wdata   = 32'd0;
        card_wvalid = 1'b0;
        card_wdata  = 32'd0;
        card_rready = 1'b0;
        buf_we      = 1'b0;
        buf_wdata   = 32'd0;
        unique case (state_q)
            S_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = desc_addr + {28'd0, fetch_i, 2'b00};
            end
            S_MEM_RD: begin
                mem_req   = 1'b1;
                mem_addr  = cur_addr;
                buf_we    = mem_ack;
                buf_wdata = mem_rdata;
            end
            S_CARD_OUT: begin
                card_wvalid = 1'b1;
                card_wdata  = buf_rdata;
            end
            S_CARD_IN: begin
                card_rready = 1'b1;
                buf_we      = card_rvalid;
                buf_wdata   = card_rdata;
            end
            S_MEM_WR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = cur_addr;
                mem_wdata = buf_rdata;
            end
            S_WBACK: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = desc_addr;
                mem_wdata = d_status & ~(32'd1 << OWN_BIT);
            end
            default: begin
            end
        endcase
    end

    assign busy       = (state_q != S_IDLE);
    assign bytes_left = remaining;

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            desc_addr  <= '0;
            d_status   <= '0;
            d_size     <= '0;
            d_buf      <= '0;
            d_next     <= '0;
            fetch_i    <= '0;
            remaining  <= '0;
            xfer_q     <= '0;
            words_left <= '0;
            chunk      <= '0;
            idx        <= '0;
            cur_addr   <= '0;
            is_wr      <= 1'b0;
            irq_raw    <= '0;
            dma_stat   <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (accept) begin
                        desc_addr <= desc_base;
                        remaining <= byte_count;
                        is_wr     <= dir_write;
                        fetch_i   <= '0;
                        irq_raw   <= '0;
                        dma_stat  <= '0;
                    end
                end
                S_FETCH: begin
                    if (mem_ack) begin
                        unique case (fetch_i)
                            2'd0: d_status <= mem_rdata;
                            2'd1: d_size   <= mem_rdata;
                            2'd2: d_buf    <= mem_rdata[31:2];
                            2'd3: d_next   <= mem_rdata;
                            default: begin
                            end
                        endcase
                        fetch_i <= fetch_i + 2'd1;
                    end
                end
                S_PLAN: begin
                    xfer_q     <= calc_bytes;
                    words_left <= calc_words;
                    cur_addr   <= {d_buf, 2'b00};
                end
                S_CHUNK: begin
                    chunk <= chunk_pick;
                    idx   <= '0;
                end
                S_MEM_RD: begin
                    if (mem_ack) begin
                        cur_addr <= cur_addr + 32'd4;
                        idx      <= last_beat ? '0 : idx + IW'(1);
                    end
                end
                S_CARD_OUT: begin
                    if (card_wready) begin
                        idx <= idx + IW'(1);
                        if (last_beat) begin
                            words_left <= words_left - WCNT_W'(chunk);
                        end
                    end
                end
                S_CARD_IN: begin
                    if (card_rvalid) begin
                        idx <= last_beat ? '0 : idx + IW'(1);
                    end
                end
                S_MEM_WR: begin
                    if (mem_ack) begin
                        cur_addr <= cur_addr + 32'd4;
                        idx      <= idx + IW'(1);
                        if (last_beat) begin
                            words_left <= words_left - WCNT_W'(chunk);
                        end
                    end
                end
                S_WBACK: begin
                    if (mem_ack) begin
                        remaining <= (remaining > xfer_q) ? remaining - xfer_q : 32'd0;
                    end
                end
                S_NEXT: begin
                    desc_addr <= d_next;
                    fetch_i   <= '0;
                end
                S_DONE: begin
                    irq_raw[RAW_DATA_DONE] <= 1'b1;
                    irq_raw[RAW_CARD_IRQ]  <= 1'b1;
                    dma_stat[STAT_SUM]     <= 1'b1;
                    if (is_wr) begin
                        dma_stat[STAT_TX] <= 1'b1;
                    end else begin
                        dma_stat[STAT_RX] <= 1'b1;
                    end
                end
                default: begin
                end
            endcase
        end
    end

endmodule

// File: rtl/sdd_dma_checker.sv
module sdd_dma_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        dir_write,
    input logic        dma_en,
    input logic        card_ready,
    input logic [31:0] byte_count,
    input logic [31:0] block_size,
    input logic        mem_req,
    input logic        mem_we,
    input logic [31:0] mem_addr,
    input logic [31:0] mem_wdata,
    input logic        mem_ack,
    input logic        card_wvalid,
    input logic [31:0] card_wdata,
    input logic        card_wready,
    input logic        card_rready,
    input logic        busy,
    input logic [31:0] bytes_left,
    input logic [31:0] irq_raw,
    input logic [9:0]  dma_stat
);

    assert_start_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start) && $past(dma_en) && $past(byte_count) != 32'd0 &&
                        $past(block_size) != 32'd0 && ($past(dir_write) || $past(card_ready)));

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req && !card_wvalid && !card_rready);

    assert_word_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> mem_addr[1:0] == 2'b00);

    assert_left_falls_R5: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) |-> bytes_left <= $past(bytes_left));

    assert_flag_values_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dma_stat == 10'h000 || dma_stat == 10'h101 || dma_stat == 10'h102);

    assert_flags_together_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dma_stat[8]) |-> !busy && irq_raw == 32'h0001_0008);

    assert_mem_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) &&
                                $stable(mem_wdata));

    assert_card_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        card_wvalid && !card_wready |=> card_wvalid && $stable(card_wdata));

endmodule

bind sdd_dma_engine sdd_dma_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .dir_write   (dir_write),
    .dma_en      (dma_en),
    .card_ready  (card_ready),
    .byte_count  (byte_count),
    .block_size  (block_size),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .mem_ack     (mem_ack),
    .card_wvalid (card_wvalid),
    .card_wdata  (card_wdata),
    .card_wready (card_wready),
    .card_rready (card_rready),
    .busy        (busy),
    .bytes_left  (bytes_left),
    .irq_raw     (irq_raw),
    .dma_stat    (dma_stat)
);

// File: tb/sim_sdd_dma_engine.sv
`timescale 1ns/100ps
module sim_sdd_dma_engine;

    localparam int MAXB  = 8192;
    localparam int MEMW  = 4096;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        dir_write = 1'b0;
    logic        dma_en = 1'b0;
    logic        card_ready = 1'b0;
    logic [31:0] byte_count = '0;
    logic [31:0] block_size = '0;
    logic [31:0] desc_base = '0;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        mem_ack = 1'b0;
    logic        card_wvalid;
    logic [31:0] card_wdata;
    logic        card_wready = 1'b0;
    logic        card_rvalid = 1'b0;
    logic [31:0] card_rdata = '0;
    logic        card_rready;
    logic        busy;
    logic [31:0] bytes_left;
    logic [31:0] irq_raw;
    logic [9:0]  dma_stat;

    always #2.5 clk = ~clk;

    sdd_dma_engine #(.MAX_DESC_BYTES(MAXB), .BURST_WORDS(4)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .dir_write(dir_write),
        .dma_en(dma_en), .card_ready(card_ready), .byte_count(byte_count),
        .block_size(block_size), .desc_base(desc_base),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .card_wvalid(card_wvalid), .card_wdata(card_wdata), .card_wready(card_wready),
        .card_rvalid(card_rvalid), .card_rdata(card_rdata), .card_rready(card_rready),
        .busy(busy), .bytes_left(bytes_left), .irq_raw(irq_raw), .dma_stat(dma_stat)
    );

    // behavioural memory and reference state
    logic [31:0] mem     [MEMW];
    logic [31:0] exp_img [MEMW];
    bit          exp_desc[MEMW];
    logic [31:0] exp_q[$];
    int          exp_writes;
    logic [31:0] exp_left;
    int          wr_seen;
    int          beats;
    int          rd_k;
    bit          rd_take;
    bit          mon_on;
    bit          hold_mem, hold_card;
    logic [31:0] hold_addr, hold_cdata;
    logic [15:0] lfsr = 16'hACE1;
    int          errors = 0;
    int          checks = 0;

    assign mem_rdata = mem[mem_addr[13:2]];

    function automatic logic [31:0] cword(input int k);
        return 32'h5A00_0000 + 32'(k) * 32'h0001_0003;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // stall patterns, card read stream and per-cycle comparison
    always @(negedge clk) begin
        if (rd_take) rd_k++;
        rd_take = 1'b0;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        mem_ack     = mem_req & (lfsr[0] | lfsr[3]);
        card_wready = lfsr[5] | lfsr[7];
        card_rvalid = lfsr[2] | lfsr[9];
        card_rdata  = cword(rd_k);
        #1;
        if (mon_on) begin
            if (hold_mem)
                chk(mem_req && mem_addr == hold_addr, "R9", mem_addr, hold_addr);
            hold_mem  = mem_req && !mem_ack;
            hold_addr = mem_addr;
            if (hold_card)
                chk(card_wvalid && card_wdata == hold_cdata, "R9", card_wdata, hold_cdata);
            hold_card  = card_wvalid && !card_wready;
            hold_cdata = card_wdata;
            if (mem_req && mem_ack) beats++;
            if (mem_req && mem_ack && mem_we) begin
                chk(mem_wdata == exp_img[mem_addr[13:2]],
                    exp_desc[mem_addr[13:2]] ? "R6" : "R5", mem_wdata,
                    exp_img[mem_addr[13:2]]);
                mem[mem_addr[13:2]] = mem_wdata;
                wr_seen++;
            end
            if (card_wvalid && card_wready) begin
                if (exp_q.size() == 0) chk(1'b0, "R5", card_wdata, 32'h0);
                else begin
                    logic [31:0] e;
                    e = exp_q.pop_front();
                    chk(card_wdata == e, "R5", card_wdata, e);
                end
            end
            if (card_rvalid && card_rready) rd_take = 1'b1;
        end
    end

    task automatic put_desc(input logic [31:0] a, input logic [31:0] st, input logic [31:0] sz,
                            input logic [31:0] ba, input logic [31:0] nx);
        mem[a[13:2]]     = st;
        mem[a[13:2] + 1] = sz;
        mem[a[13:2] + 2] = ba;
        mem[a[13:2] + 3] = nx;
    endtask

    // reference walk of the descriptor chain
    task automatic model(input bit wr, input logic [31:0] base, input logic [31:0] bytes);
        logic [31:0] rem, a, st, sz, ba, nx, n;
        int k;
        k = 0;
        rem = bytes;
        a = base;
        exp_q.delete();
        exp_img = mem;
        for (int i = 0; i < MEMW; i++) exp_desc[i] = 1'b0;
        exp_writes = 0;
        while (rem != 0) begin
            st = mem[a[13:2]];
            sz = mem[a[13:2] + 1];
            ba = mem[a[13:2] + 2] & 32'hFFFF_FFFC;
            nx = mem[a[13:2] + 3];
            if (sz == 0 || sz > MAXB) sz = MAXB;
            n = (sz < rem) ? sz : rem;
            for (int w = 0; w < int'((n + 3) / 4); w++) begin
                logic [31:0] wa;
                wa = ba + 32'(4 * w);
                if (wr) exp_q.push_back(mem[wa[13:2]]);
                else begin
                    exp_img[wa[13:2]] = cword(k);
                    k++;
                    exp_writes++;
                end
            end
            exp_img[a[13:2]]  = st & 32'h7FFF_FFFF;
            exp_desc[a[13:2]] = 1'b1;
            exp_writes++;
            rem = rem - n;
            if (st[2]) break;
            a = nx;
        end
        exp_left = rem;
    endtask

    task automatic run(input bit wr, input logic [31:0] base, input logic [31:0] bytes,
                       input string tag);
        model(wr, base, bytes);
        rd_k = 0;
        wr_seen = 0;
        hold_mem = 0;
        hold_card = 0;
        mon_on = 1'b1;
        @(negedge clk);
        dir_write = wr; byte_count = bytes; desc_base = base;
        block_size = 32'd512; dma_en = 1'b1; card_ready = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R1", {31'd0, busy}, 32'd1);
        chk(irq_raw == 32'd0 && dma_stat == 10'd0, "R8", irq_raw, 32'd0);
        while (busy) @(negedge clk);
        #2;
        chk(exp_q.size() == 0, "R5", exp_q.size(), 32'd0);
        chk(wr_seen == exp_writes, "R6", wr_seen, exp_writes);
        chk(bytes_left == exp_left, "R7", bytes_left, exp_left);
        chk(irq_raw == 32'h0001_0008, "R8", irq_raw, 32'h0001_0008);
        chk(dma_stat == (wr ? 10'h101 : 10'h102), "R8", {22'd0, dma_stat},
            wr ? 32'h101 : 32'h102);
        mon_on = 1'b0;
        $display("done: %s", tag);
    endtask

    task automatic reject(input bit en, input logic [31:0] bc, input logic [31:0] bs,
                          input bit wr, input bit crdy);
        logic [31:0] left0, irq0;
        logic [9:0] st0;
        left0 = bytes_left; irq0 = irq_raw; st0 = dma_stat;
        beats = 0;
        hold_mem = 0;
        hold_card = 0;
        mon_on = 1'b1;
        @(negedge clk);
        dma_en = en; byte_count = bc; block_size = bs; dir_write = wr;
        card_ready = crdy; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int c = 0; c < 6; c++) begin
            chk(busy == 1'b0, "R1", {31'd0, busy}, 32'd0);
            @(negedge clk);
        end
        #2;
        chk(beats == 0, "R1", beats, 32'd0);
        chk(bytes_left == left0, "R1", bytes_left, left0);
        chk(irq_raw == irq0 && dma_stat == st0, "R1", irq_raw, irq0);
        mon_on = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R7 watchdog: actual=busy expected=idle");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        for (int i = 0; i < MEMW; i++) mem[i] = 32'h1000_0000 + 32'(i) * 32'h0000_9E37;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        chk(!busy && !mem_req && !card_wvalid && !card_rready, "R1", {31'd0, busy}, 32'd0);
        chk(irq_raw == 32'd0 && dma_stat == 10'd0 && bytes_left == 32'd0, "R8",
            irq_raw, 32'd0);

        // R2 R4: single last descriptor with unaligned buffer word
        put_desc(32'h040, 32'h8000_000C, 32'd16, 32'h0000_0203, 32'h0);
        run(1'b1, 32'h040, 32'd16, "R2 R4 single transmit");

        // R7: chain followed out of address order, stopped by the last flag with bytes left
        put_desc(32'h080, 32'h8000_0018, 32'd12, 32'h0000_0300, 32'h0A0);
        put_desc(32'h0A0, 32'h8000_0010, 32'd10, 32'h0000_0400, 32'h090);
        put_desc(32'h090, 32'h8000_0014, 32'd24, 32'h0000_0500, 32'h0);
        run(1'b1, 32'h080, 32'd100, "R7 last flag stop");

        // R3 R7: receive, zero size, count runs out, trap descriptor after it
        put_desc(32'h0C0, 32'h8000_0018, 32'd24, 32'h0000_0600, 32'h0D0);
        put_desc(32'h0D0, 32'h8000_0010, 32'd0,  32'h0000_0700, 32'h0E0);
        put_desc(32'h0E0, 32'h8000_0004, 32'd16, 32'h0000_0780, 32'h0);
        run(1'b0, 32'h0C0, 32'd40, "R3 R7 receive count stop");

        // R3: oversized size clamps, count just past the maximum
        put_desc(32'h100, 32'h8000_0018, 32'h0002_0000, 32'h0000_1000, 32'h110);
        put_desc(32'h110, 32'h8000_0014, 32'd8, 32'h0000_3000, 32'h0);
        run(1'b1, 32'h100, 32'd8200, "R3 clamp");

        // R1: refused starts
        reject(1'b0, 32'd77, 32'd512, 1'b1, 1'b1);
        reject(1'b1, 32'd0,  32'd512, 1'b1, 1'b1);
        reject(1'b1, 32'd77, 32'd0,   1'b1, 1'b1);
        reject(1'b1, 32'd77, 32'd512, 1'b0, 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule